// File: doc/BRIEF.md
# Ratio-clocked AHB-Lite to APB3 bridge

This bridge lets a fast AHB-Lite master reach a peripheral bus whose clock runs at one, one half or one quarter of the system clock. Every accepted AHB transfer becomes one APB3 access on a single peripheral select. The peripheral clock is not a separate clock. It is a clock-enable pulse, `pclk_en`, which the bridge derives from the system clock and also drives out so that the peripherals can use it. The APB outputs change only on edges where that enable is high. While the slow access is in flight, the bridge holds `hready` low for the extra fast cycles the ratio costs.

The two sides follow the back-pressure rules of their protocols. On the AHB side, a transfer is accepted in an address phase where `hready` is high and `htrans` requests a transfer. Its data phase lasts until `hready` returns high. Write data is taken from `hwdata` during that data phase. On the APB side, the peripheral stretches the access phase by holding `pready` low, and every enabled edge with `pready` low adds one slow cycle. An error from the peripheral turns into a two-cycle AHB error response. `ratio_sel` is static configuration and is changed only while the bus is idle.

Top module: `ahb_apb_ratio_bridge`

## Requirements
- R1: During and after reset, with no transfer requested, `hready`=1, `hresp`=0, `psel`=0 and `penable`=0.
- R2: `ratio_sel` 2'b00 gives `pclk_en` high every cycle, 2'b01 every second cycle, and 2'b10 every fourth cycle. Code 2'b11 behaves as 2'b10.
- R3: `htrans` values 2'b10 (non-sequential) and 2'b11 (sequential) start an APB access. Values 2'b00 (idle) and 2'b01 (busy) get a zero-wait OKAY: `hready` stays 1, `hresp` stays 0 and `psel` stays 0.
- R4: Each access has a setup phase (`psel`=1, `penable`=0) lasting exactly one slow cycle, i.e. N system cycles at ratio N, followed by `penable`=1. `penable` is never high without `psel`, and `paddr`, `pwrite` and `pwdata` hold steady while `psel` stays high.
- R5: `psel` and `penable` change only after an edge on which `pclk_en` was high.
- R6: A write presents the captured address on `paddr`, drives `pwrite`=1, and puts the data-phase `hwdata` on `pwdata`.
- R7: A read drives `pwrite`=0 and returns the `prdata` sampled at completion on `hrdata`, in the cycle where `hready` returns high.
- R8: While the peripheral holds `pready` low in the access phase, `hready` stays low. Each enabled edge with `pready` low adds N system cycles at ratio N.
- R9: `pslverr` high at completion gives an AHB error response of two cycles, with `hresp`=1 in both, `hready`=0 in the first and `hready`=1 in the second.
- R10: Counted from the accepting edge, `hready` is low (excluding the first error-response cycle) for 3+W cycles at ratio 1. At ratio N it is low for between 2N+1+W·N and 3N+W·N cycles, where W is the number of peripheral wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ratio_sel | input | 2 | Clock ratio code (00 1:1, 01 2:1, 10/11 4:1) |
| htrans | input | 2 | AHB transfer type |
| haddr | input | 20 | AHB byte address |
| hwrite | input | 1 | AHB write (1) or read (0) |
| hwdata | input | 32 | AHB write data, data phase |
| hready | output | 1 | AHB ready, low while a transfer is stalled |
| hresp | output | 1 | AHB error response |
| hrdata | output | 32 | AHB read data |
| pclk_en | output | 1 | Peripheral clock enable |
| paddr | output | 20 | APB address |
| psel | output | 1 | APB select |
| penable | output | 1 | APB enable (access phase) |
| pwrite | output | 1 | APB write direction |
| pwdata | output | 32 | APB write data |
| prdata | input | 32 | APB read data |
| pready | input | 1 | APB ready from the peripheral |
| pslverr | input | 1 | APB error from the peripheral |

## Verification
The hardest case to reach is a transfer accepted at every possible phase of the ratio counter, with a new address phase arriving in the very cycle the previous one completes. Only then do both the alignment wait before setup and the pipelined hand-over get exercised. The stimulus issues the vector table back to back and switches the ratio between vectors. It also varies the number of peripheral wait states, so that completions, error responses included, fall on different counter phases. The cycles for which `hready` stays low are then checked against the bounds that follow from the ratio and the number of wait states.

// File: rtl/ahbapb_pkg.sv
package ahbapb_pkg;

  localparam logic [1:0] HT_IDLE = 2'b00;
  localparam logic [1:0] HT_BUSY = 2'b01;
  localparam logic [1:0] HT_NSEQ = 2'b10;
  localparam logic [1:0] HT_SEQ  = 2'b11;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_SETUP  = 2'd1,
    SQ_ACCESS = 2'd2
  } seq_state_e;

endpackage

// File: rtl/ahbapb_rate_gen.sv
module ahbapb_rate_gen #(
  parameter int RSEL_W         = 2,
  parameter int RATIO_LOG2_MAX = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RSEL_W-1:0] ratio_sel,
  output logic              pclk_en
);

  localparam int CNT_W = (RATIO_LOG2_MAX < 1) ? 1 : RATIO_LOG2_MAX;

  logic [CNT_W-1:0] cnt_q;
  int               eff_log2;

  // free-running phase counter; every power-of-two ratio divides its period
  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + CNT_W'(1);
  end

  always_comb begin
    eff_log2 = (int'(ratio_sel) > RATIO_LOG2_MAX) ? RATIO_LOG2_MAX : int'(ratio_sel);
    pclk_en  = 1'b1;
    for (int i = 0; i < CNT_W; i++) begin
      if (i < eff_log2 && cnt_q[i]) pclk_en = 1'b0;
    end
  end

endmodule

// File: rtl/ahbapb_seq.sv
module ahbapb_seq
  import ahbapb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pclk_en,
  input  logic req,
  input  logic pready,
  input  logic pslverr,
  output logic psel,
  output logic penable,
  output logic launch,
  output logic done,
  output logic fail
);

  seq_state_e state_q, state_d;

  always_comb begin
    launch  = (state_q == SQ_IDLE) && req && pclk_en;
    done    = (state_q == SQ_ACCESS) && pclk_en && pready;
    fail    = done && pslverr;
    psel    = (state_q != SQ_IDLE);
    penable = (state_q == SQ_ACCESS);
    state_d = state_q;
    case (state_q)
      SQ_IDLE:   if (launch)  state_d = SQ_SETUP;
      SQ_SETUP:  if (pclk_en) state_d = SQ_ACCESS;
      SQ_ACCESS: if (done)    state_d = SQ_IDLE;
      default:                state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/ahbapb_front.sv
module ahbapb_front
  import ahbapb_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        htrans,
  input  logic [ADDR_W-1:0] haddr,
  input  logic              hwrite,
  input  logic [DATA_W-1:0] hwdata,
  output logic              hready,
  output logic              hresp,
  output logic [DATA_W-1:0] hrdata,
  input  logic              launch,
  input  logic              done,
  input  logic              fail,
  input  logic [DATA_W-1:0] prdata,
  output logic              req,
  output logic [ADDR_W-1:0] paddr,
  output logic              pwrite,
  output logic [DATA_W-1:0] pwdata
);

  logic              hready_q, hresp_q, err_q, req_q, wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              start;

  assign start = (htrans == HT_NSEQ) || (htrans == HT_SEQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hready_q <= 1'b1;
      hresp_q  <= 1'b0;
      err_q    <= 1'b0;
      req_q    <= 1'b0;
      wr_q     <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
    end else begin
      // address phase accepted only while the bus is ready
      if (hready_q) begin
        hresp_q <= 1'b0;
        if (start) begin
          addr_q   <= haddr;
          wr_q     <= hwrite;
          req_q    <= 1'b1;
          hready_q <= 1'b0;
        end
      end
      // write data is valid in the data phase, taken at setup launch
      if (launch) begin
        req_q   <= 1'b0;
        wdata_q <= hwdata;
      end
      if (done) begin
        if (fail) begin
          hresp_q <= 1'b1;
          err_q   <= 1'b1;
        end else begin
          hready_q <= 1'b1;
          if (!wr_q) rdata_q <= prdata;
        end
      end
      // second cycle of the error response
      if (err_q) begin
        err_q    <= 1'b0;
        hready_q <= 1'b1;
      end
    end
  end

  assign hready = hready_q;
  assign hresp  = hresp_q;
  assign hrdata = rdata_q;
  assign req    = req_q;
  assign paddr  = addr_q;
  assign pwrite = wr_q;
  assign pwdata = wdata_q;

endmodule

// File: rtl/ahb_apb_ratio_bridge.sv
module ahb_apb_ratio_bridge #(
  parameter int ADDR_W         = 20,
  parameter int DATA_W         = 32,
  parameter int RSEL_W         = 2,
  parameter int RATIO_LOG2_MAX = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RSEL_W-1:0] ratio_sel,
  input  logic [1:0]        htrans,
  input  logic [ADDR_W-1:0] haddr,
  input  logic              hwrite,
  input  logic [DATA_W-1:0] hwdata,
  output logic              hready,
  output logic              hresp,
  output logic [DATA_W-1:0] hrdata,
  output logic              pclk_en,
  output logic [ADDR_W-1:0] paddr,
  output logic              psel,
  output logic              penable,
  output logic              pwrite,
  output logic [DATA_W-1:0] pwdata,
  input  logic [DATA_W-1:0] prdata,
  input  logic              pready,
  input  logic              pslverr
);

  logic req, launch, done, fail;

  ahbapb_rate_gen #(
    .RSEL_W        (RSEL_W),
    .RATIO_LOG2_MAX(RATIO_LOG2_MAX)
  ) u_rate (
    .clk      (clk),
    .rst_n    (rst_n),
    .ratio_sel(ratio_sel),
    .pclk_en  (pclk_en)
  );

  ahbapb_front #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_front (
    .clk   (clk),
    .rst_n (rst_n),
    .htrans(htrans),
    .haddr (haddr),
    .hwrite(hwrite),
    .hwdata(hwdata),
    .hready(hready),
    .hresp (hresp),
    .hrdata(hrdata),
    .launch(launch),
    .done  (done),
    .fail  (fail),
    .prdata(prdata),
    .req   (req),
    .paddr (paddr),
    .pwrite(pwrite),
    .pwdata(pwdata)
  );

  ahbapb_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .pclk_en(pclk_en),
    .req    (req),
    .pready (pready),
    .pslverr(pslverr),
    .psel   (psel),
    .penable(penable),
    .launch (launch),
    .done   (done),
    .fail   (fail)
  );

endmodule

// File: rtl/ahbapb_checker.sv
module ahbapb_checker #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        htrans,
  input logic              hready,
  input logic              hresp,
  input logic              pclk_en,
  input logic              psel,
  input logic              penable,
  input logic              pready,
  input logic [ADDR_W-1:0] paddr,
  input logic              pwrite,
  input logic [DATA_W-1:0] pwdata
);

  AST_IDLE_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
    (hready && !hresp && !htrans[1]) |=> (hready && !psel)); // R3

  AST_SETUP_TO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !penable && pclk_en) |=> (psel && penable)); // R4

  AST_ENABLE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    penable |-> psel); // R4

  AST_APB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && $past(psel)) |-> ($stable(paddr) && $stable(pwrite) && $stable(pwdata))); // R4

  AST_SLOW_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !pclk_en |=> ($stable(psel) && $stable(penable))); // R5

  AST_STALL_ON_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && !pready) |-> !hready); // R8

  AST_ERR_TWO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (hresp && !hready) |=> (hresp && hready)); // R9

endmodule

bind ahb_apb_ratio_bridge ahbapb_checker #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .htrans (htrans),
  .hready (hready),
  .hresp  (hresp),
  .pclk_en(pclk_en),
  .psel   (psel),
  .penable(penable),
  .pready (pready),
  .paddr  (paddr),
  .pwrite (pwrite),
  .pwdata (pwdata)
);

// File: tb/ahb_apb_ratio_bridge_bench.sv
`timescale 1ns/1ps
module ahb_apb_ratio_bridge_bench;

  typedef struct packed {
    logic [1:0]  ratio;
    logic        wr;
    logic [19:0] addr;
    logic [31:0] wdata;
    logic [1:0]  waits;
    logic        err;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b1, 20'h00010, 32'hDEADBEEF, 2'd0, 1'b0},
    '{2'd0, 1'b0, 20'h00010, 32'h00000000, 2'd0, 1'b0},
    '{2'd1, 1'b1, 20'hFFFFC, 32'h12345678, 2'd1, 1'b0},
    '{2'd1, 1'b0, 20'h80004, 32'h00000000, 2'd2, 1'b0},
    '{2'd2, 1'b1, 20'h00000, 32'hA5A5A5A5, 2'd0, 1'b1},
    '{2'd2, 1'b0, 20'h3C3C0, 32'h00000000, 2'd3, 1'b0},
    '{2'd0, 1'b0, 20'h7FFF8, 32'h00000000, 2'd1, 1'b1},
    '{2'd3, 1'b1, 20'h01234, 32'h0F0F0F0F, 2'd1, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ratio_sel = 2'd0;
  logic [1:0]  htrans = 2'b00;
  logic [19:0] haddr = '0;
  logic        hwrite = 1'b0;
  logic [31:0] hwdata = '0;
  logic        hready, hresp, pclk_en, psel, penable, pwrite;
  logic [31:0] hrdata, pwdata, prdata;
  logic [19:0] paddr;
  logic        pready, pslverr;

  always #10 clk = ~clk;

  ahb_apb_ratio_bridge u_ahb_apb_ratio_bridge (
    .clk(clk), .rst_n(rst_n), .ratio_sel(ratio_sel),
    .htrans(htrans), .haddr(haddr), .hwrite(hwrite), .hwdata(hwdata),
    .hready(hready), .hresp(hresp), .hrdata(hrdata),
    .pclk_en(pclk_en), .paddr(paddr), .psel(psel), .penable(penable),
    .pwrite(pwrite), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr)
  );

  // peripheral model
  int          wait_n = 0;
  logic        err_en = 1'b0;
  int          wcnt = 0;
  logic [19:0] cap_addr = '0;
  logic        cap_wr = 1'b0;
  logic [31:0] cap_data = '0;

  assign pready  = (wcnt >= wait_n);
  assign pslverr = err_en && pready && psel && penable;
  assign prdata  = {12'hC3A, paddr};

  always @(posedge clk) begin
    if (!rst_n) wcnt <= 0;
    else if (pclk_en) begin
      if (psel && penable && !pready) wcnt <= wcnt + 1;
      else if (!(psel && penable))   wcnt <= 0;
      if (psel && penable && pready) begin
        cap_addr <= paddr;
        cap_wr   <= pwrite;
        cap_data <= pwdata;
        wcnt     <= 0;
      end
    end
  end

  // protocol monitor, sampled away from the active edge
  int   n_vec = 0, n_bad = 0;
  int   viol = 0, setup_run = 0, last_setup = 0;
  logic prev_en = 1'b1, prev_psel = 1'b0, prev_pen = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!prev_en && (psel != prev_psel || penable != prev_pen)) viol++;
      if (psel && !penable) setup_run++;
      else if (psel && penable && setup_run != 0) begin
        last_setup = setup_run;
        setup_run  = 0;
      end
    end
    prev_en   = pclk_en;
    prev_psel = psel;
    prev_pen  = penable;
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a negedge where hready is high; returns at one where hready is high again
  task automatic ahb_xfer(input vec_t v, input logic use_seq);
    int   low, lo_b, hi_b, n;
    logic e1;
    ratio_sel = v.ratio;
    wait_n    = int'(v.waits);
    err_en    = v.err;
    haddr     = v.addr;
    hwrite    = v.wr;
    htrans    = use_seq ? 2'b11 : 2'b10;
    @(negedge clk);
    htrans = 2'b00;
    hwdata = v.wdata;
    haddr  = '0;
    low = 0; e1 = 1'b0;
    for (int g = 0; g < 200 && !hready; g++) begin
      if (hresp) e1 = 1'b1; else low++;
      @(negedge clk);
    end
    n    = (v.ratio == 2'd0) ? 1 : (v.ratio == 2'd1) ? 2 : 4;
    lo_b = 2*n + 1 + int'(v.waits)*n;
    hi_b = 3*n + int'(v.waits)*n;
    if (n == 1) chk(low == 3 + int'(v.waits), "R10 exact stall at 1:1", low, 3 + int'(v.waits));
    else        chk(low >= lo_b && low <= hi_b, "R10 stall within ratio bounds", low, lo_b);
    chk(low >= 1 + int'(v.waits)*n, "R8 wait states stretch hready", low, 1 + int'(v.waits)*n);
    chk(e1 == v.err, "R9 first error cycle hready low", e1, v.err);
    chk(hresp == v.err, "R9 second error cycle hready high", hresp, v.err);
    chk(last_setup == n, "R4 setup lasts one slow cycle", last_setup, n);
    chk(cap_addr == v.addr, "R6 paddr carries captured address", cap_addr, v.addr);
    chk(cap_wr == v.wr, "R6 pwrite direction", cap_wr, v.wr);
    if (v.wr) chk(cap_data == v.wdata, "R6 pwdata from data phase", cap_data, v.wdata);
    else if (!v.err) chk(hrdata == {12'hC3A, v.addr}, "R7 read data returned", hrdata, {12'hC3A, v.addr});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run hung actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk(hready && !hresp && !psel && !penable, "R1 outputs in reset", {hready, hresp, psel, penable}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(hready && !hresp && !psel && !penable, "R1 outputs after reset", {hready, hresp, psel, penable}, 4'b1000);

    // R2: enable cadence per ratio code
    for (int r = 0; r < 4; r++) begin
      ratio_sel = 2'(r);
      cnt = 0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (pclk_en) cnt++;
      end
      chk(cnt == ((r == 0) ? 8 : (r == 1) ? 4 : 2), "R2 pclk_en cadence", cnt, (r == 0) ? 8 : (r == 1) ? 4 : 2);
    end

    // R3: idle and busy get zero-wait OKAY without touching the APB bus
    ratio_sel = 2'd1;
    htrans = 2'b01;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(hready && !hresp && !psel, "R3 busy zero-wait okay", {hready, hresp, psel}, 3'b100);
    end
    htrans = 2'b00;
    @(negedge clk);
    chk(hready && !hresp && !psel, "R3 idle zero-wait okay", {hready, hresp, psel}, 3'b100);

    // vector table, back to back; odd vectors use a sequential transfer (R3)
    for (int i = 0; i < NV; i++) ahb_xfer(VECS[i], (i % 2) == 1);

    // back-to-back at 4:1 from a shifted counter phase
    @(negedge clk);
    ahb_xfer('{2'd2, 1'b0, 20'h0ABCD, 32'h0, 2'd0, 1'b0}, 1'b0);
    ahb_xfer('{2'd2, 1'b1, 20'h0ABCE, 32'h55AA55AA, 2'd2, 1'b0}, 1'b1);

    @(negedge clk);
    chk(viol == 0, "R5 APB changes only after enabled edges", viol, 0);
    chk(!psel && hready, "R3 bus idle at end", {psel, hready}, 2'b01);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule